// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Timer

This timer runs a counter that climbs from zero to a period limit and then falls back to zero, over and over. That makes a triangle waveform. Two compare channels watch the counter and switch their pins on the way up and on the way down, so each pulse sits at the centre of its period. This suits motor drives and other loads where the phase of the edges matters.

The period limit comes from one of two places: a dedicated period register, or the first compare register. Software writes new period, compare and limit-select values into shadow copies. The working copies take those values only on the timer tick in which the counter sits at zero. Because of this, a period always completes with one limit and one set of thresholds, and both its length and its symmetry are preserved. Event flags record the bottom of the count, compare hits and hits of the period register. Each flag stays set until software clears it by writing ones. The counter only moves on clock cycles where the tick enable is high.

Top module: `cpwm_timer`

## Requirements
- R1: On each enabled tick the count changes by exactly one. From zero it rises to the active limit L and then falls back to zero, so one period is 2*L ticks.
- R2: The count shows the limit value L for exactly one tick. The next tick shows L-1. L may be as small as 3 or as large as the all-ones value of the counter width.
- R3: Bit 0 of the control word (address 3) picks the limit source: 0 selects the period register (address 0) and 1 selects compare A (address 1). The choice takes effect at the next bottom.
- R4: In non-inverting mode a pin goes low when its compare value matches the count while rising, and goes high on a match while falling. A match at zero counts as rising, and a match at the limit counts as falling.
- R5: Control bit 1 (channel A) and bit 2 (channel B) make the pin levels the reverse of R4.
- R6: Writes to addresses 0, 1 and 2, and control bit 0, land in shadow copies. These are copied into the working values on the tick where the count is zero, and that period still compares against the old values.
- R7: Flag bit 0 is set on every tick where the count is zero.
- R8: Flag bit 1 (A) and flag bit 2 (B) are set on a tick where the count equals that channel's working compare value. Flag bit 3 is set when the count equals the working period register and the limit comes from the period register.
- R9: Flags stay set until a write to address 4 carries a 1 in their bit position. If a new event arrives in the same cycle as a clear, the flag stays set.
- R10: Over a full period, a non-inverted pin with compare value c (0 <= c <= L) is high for 2*c ticks: never high for c = 0, always high for c = L. An inverted pin is high for 2*L-2*c ticks.
- R11: Reset clears the count, the shadows, the working values and the flags. It sets the direction to up and drives both pins low.
- R12: While the tick enable is low, the count and the pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 compare A, 2 compare B, 3 control, 4 flag clear) |
| wr_data | input | W | Write data |
| count | output | W | Present counter value |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |
| flags | output | 4 | Sticky events: bit 0 bottom, 1 compare A, 2 compare B, 3 period register |

## Verification
The bench builds the timer with an 8-bit counter. This keeps the limits small enough to sweep every limit from 3 to 6 under both limit sources, every compare value from zero to one past the limit on both channels, and all four polarity pairs. At that width a single run also reaches the full-scale limit of 255. It covers the boundary cases of R10 (compare at zero, at the limit and above it), a shadow write made in the middle of a period, clears made while the counter is halted, and held ticks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [2:0] {
        ADR_PERIOD = 3'd0,
        ADR_CMP_A  = 3'd1,
        ADR_CMP_B  = 3'd2,
        ADR_CTRL   = 3'd3,
        ADR_FLAGS  = 3'd4
    } reg_addr_e;

    localparam int NUM_CH     = 2;
    localparam int NUM_FLAGS  = 4;
    localparam int FLG_BOTTOM = 0;
    localparam int FLG_CMP0   = 1;
    localparam int FLG_PERIOD = 3;
    localparam int CTL_TOPSEL = 0;
    localparam int CTL_INV0   = 1;

    // Pin level after a match: rising half drives the inactive level.
    function automatic logic match_level(input logic falling, input logic inv);
        return falling ^ inv;
    endfunction

endpackage

// File: rtl/cpwm_regfile.sv
module cpwm_regfile
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_addr,
    input  logic [W-1:0]               wr_data,
    input  logic                       load,
    output logic [W-1:0]               act_period,
    output logic [NUM_CH-1:0][W-1:0]   act_cmp,
    output logic                       act_top_sel,
    output logic [NUM_CH-1:0]          inv
);

    typedef struct packed {
        logic                     top_sel;
        logic [W-1:0]             period;
        logic [NUM_CH-1:0][W-1:0] cmp;
    } shadow_t;

    shadow_t shadow_q;
    shadow_t work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            work_q   <= '0;
            inv      <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_PERIOD)
                shadow_q.period <= wr_data;
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_en && wr_addr == 3'(int'(ADR_CMP_A) + i))
                    shadow_q.cmp[i] <= wr_data;
            end
            if (wr_en && wr_addr == ADR_CTRL) begin
                shadow_q.top_sel <= wr_data[CTL_TOPSEL];
                for (int i = 0; i < NUM_CH; i++)
                    inv[i] <= wr_data[CTL_INV0 + i];
            end
            if (load)
                work_q <= shadow_q;
        end
    end

    assign act_period  = work_q.period;
    assign act_cmp     = work_q.cmp;
    assign act_top_sel = work_q.top_sel;

    // R6
    shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> work_q == $past(shadow_q));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load) |=> $stable(work_q));

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         at_bottom,
    output logic         falling
);

    localparam logic [W-1:0] ONE = W'(1);

    logic dir_up;

    assign at_bottom = (cnt == '0);
    assign falling   = !at_bottom && (cnt >= top || !dir_up);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            if (at_bottom) begin
                cnt    <= ONE;
                dir_up <= 1'b1;
            end else if (dir_up && cnt >= top) begin
                cnt    <= cnt - ONE;
                dir_up <= 1'b0;
            end else if (dir_up) begin
                cnt <= cnt + ONE;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // R1
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

    // R2
    top_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != '0 && cnt == top) |=> cnt == $past(cnt) - ONE);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         falling,
    input  logic         inv,
    output logic         hit,
    output logic         pin
);

    assign hit = tick && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (hit)
            pin <= match_level(falling, inv);
    end

    // R4
    rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !falling && !inv) |=> !pin);

    // R5
    rise_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !falling && inv) |=> pin);

    // R12
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(pin));

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         count,
    output logic                 pwm_a,
    output logic                 pwm_b,
    output logic [NUM_FLAGS-1:0] flags
);

    localparam int FW = NUM_FLAGS;

    logic [W-1:0]             act_period;
    logic [NUM_CH-1:0][W-1:0] act_cmp;
    logic                     act_top_sel;
    logic [NUM_CH-1:0]        inv;
    logic [W-1:0]             top_val;
    logic                     at_bottom;
    logic                     falling;
    logic [NUM_CH-1:0]        hit;
    logic [NUM_CH-1:0]        pin;
    logic [FW-1:0]            set_vec;
    logic [FW-1:0]            clr_vec;

    cpwm_regfile #(.W(W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load        (tick && at_bottom),
        .act_period  (act_period),
        .act_cmp     (act_cmp),
        .act_top_sel (act_top_sel),
        .inv         (inv)
    );

    assign top_val = act_top_sel ? act_cmp[0] : act_period;

    cpwm_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .top       (top_val),
        .cnt       (count),
        .at_bottom (at_bottom),
        .falling   (falling)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cpwm_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt     (count),
            .cmp     (act_cmp[g]),
            .falling (falling),
            .inv     (inv[g]),
            .hit     (hit[g]),
            .pin     (pin[g])
        );
        assign set_vec[FLG_CMP0 + g] = hit[g];
    end

    assign set_vec[FLG_BOTTOM] = tick && at_bottom;
    assign set_vec[FLG_PERIOD] = tick && !act_top_sel && (count == act_period);
    assign clr_vec = (wr_en && wr_addr == ADR_FLAGS) ? wr_data[FW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr_vec) | set_vec;
    end

    assign pwm_a = pin[0];
    assign pwm_b = pin[1];

    // R7
    bottom_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0) |=> flags[FLG_BOTTOM]);

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && !pwm_a && !pwm_b && flags == '0));

endmodule

// File: tb/test_cpwm_timer.sv
module test_cpwm_timer;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         pwm_a, pwm_b;
    logic [3:0]   flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpwm_timer #(.W(W)) i_cpwm_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, return at the next falling edge.
    task automatic step(input logic t, input logic we, input logic [2:0] a,
                        input logic [W-1:0] d);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_to_zero();
        for (int k = 0; k < 1200 && count != 0; k++) step(1, 0, 0, 0);
    endtask

    // Measure one period starting at a bottom; returns high counts and triangle errors.
    task automatic measure(input int top, input int wr_at, input logic [2:0] wa,
                           input logic [W-1:0] wd, output int hi_a, output int hi_b,
                           output int tri_err);
        hi_a = 0; hi_b = 0; tri_err = 0;
        for (int j = 1; j <= 2 * top; j++) begin
            if (j == 1) step(1, 1, 3'd4, 8'h0F);
            else if (j == wr_at) step(1, 1, wa, wd);
            else step(1, 0, 0, 0);
            if (int'(count) != ((j <= top) ? j : 2 * top - j)) tri_err++;
            hi_a += pwm_a;
            hi_b += pwm_b;
        end
    endtask

    task automatic config_run(input int top, input bit sel, input int ca, input int cb,
                              input int inv);
        int ha, hb, te, exp_a, exp_b;
        step(1, 1, 3'd0, W'(sel ? top + 5 : top));
        step(1, 1, 3'd1, W'(ca));
        step(1, 1, 3'd2, W'(cb));
        step(1, 1, 3'd3, W'({inv[1:0], sel}));
        run_to_zero();
        step(1, 0, 0, 0);
        run_to_zero();
        measure(top, 0, 0, 0, ha, hb, te);
        chk(te == 0, sel ? "R3" : "R1", "triangle mismatches", te, 0);
        exp_a = inv[0] ? 2 * top - 2 * ca : 2 * ca;
        exp_b = inv[1] ? 2 * top - 2 * cb : 2 * cb;
        if (ca <= top) chk(ha == exp_a, inv[0] ? "R5" : "R10", "pin A high ticks", ha, exp_a);
        if (cb <= top) chk(hb == exp_b, inv[1] ? "R5" : "R4", "pin B high ticks", hb, exp_b);
        // R7 R8 R9: bottom, compare and period flags after a cleared period
        chk(flags == {!sel, cb <= top, ca <= top, 1'b1}, "R8", "flags after period",
            int'(flags), int'({!sel, cb <= top, ca <= top, 1'b1}));
    endtask

    initial begin
        int ha, hb, te;
        logic [3:0] f0;
        logic [W-1:0] c0;
        logic pa0, pb0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(count == 0, "R11", "count after reset", int'(count), 0);
        chk(pwm_a == 0 && pwm_b == 0, "R11", "pins after reset", int'({pwm_a, pwm_b}), 0);
        chk(flags == 0, "R11", "flags after reset", int'(flags), 0);

        // Sweep limit, source, compares and polarities
        for (int sel = 0; sel < 2; sel++)
            for (int top = 3; top <= 6; top++)
                for (int ca = 0; ca <= top + 1; ca++)
                    for (int cb = 0; cb <= top + 1; cb++)
                        for (int inv = 0; inv < 4; inv++)
                            if (sel == 0 || ca == top)
                                config_run(top, sel[0], ca, cb, inv);

        // R2 full-scale limit
        config_run(255, 1'b0, 100, 255, 0);

        // R6 mid-period shadow write keeps the running period intact
        config_run(5, 1'b0, 2, 3, 0);
        measure(5, 3, 3'd1, 8'd4, ha, hb, te);
        chk(ha == 4, "R6", "high ticks in period with pending write", ha, 4);
        measure(5, 0, 0, 0, ha, hb, te);
        chk(ha == 8, "R6", "high ticks after bottom load", ha, 8);

        // R12 hold while tick is low, R9 selective clear
        run_to_zero();
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        c0 = count; pa0 = pwm_a; pb0 = pwm_b; f0 = flags;
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0);
        chk(count == c0, "R12", "count while idle", int'(count), int'(c0));
        chk(pwm_a == pa0 && pwm_b == pb0, "R12", "pins while idle",
            int'({pwm_a, pwm_b}), int'({pa0, pb0}));
        chk(flags == f0, "R9", "flags held while idle", int'(flags), int'(f0));
        step(0, 1, 3'd4, 8'h02);
        chk(flags == (f0 & 4'b1101), "R9", "clear of bit 1 only", int'(flags),
            int'(f0 & 4'b1101));
        step(0, 1, 3'd4, 8'h0F);
        chk(flags == 0, "R9", "clear all", int'(flags), 0);

        // R9 set wins over clear at bottom
        run_to_zero();
        step(1, 1, 3'd4, 8'h01);
        chk(flags[0] == 1'b1, "R7", "bottom flag survives same-cycle clear", int'(flags[0]), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule